// File: doc/BRIEF.md
# 4:2:2 Component Word Stream Splitter

This block sits at the front of a video output path. It receives one 10-bit word per clock carrying interleaved 4:2:2 component video, where each group of four words holds a blue-difference sample, a luma sample, a red-difference sample and a second, isolated luma sample. It splits the words into a luma lane and a paired chroma lane and marks each with its own valid strobe. Downstream interpolators can then take luma at half the word rate and chroma pairs at a quarter of it.

A single sync input sets the position in the four-word cycle. A falling transition on sync marks the word present in the low cycle as the first blue-difference sample. After that the block keeps counting on its own. Sync may then stay low, or it may pulse before every blue-difference word, and the alignment stays the same either way. Every word is passed through as a plain 10-bit value. This includes blanking, timing-reference, ancillary and time-code words. Sources with 8-bit samples place them in the upper bits.

Top module: `vid422_demux`

## Requirements
- R1: While reset is high, and on the first cycle after it, both valid strobes are low and all three data outputs are zero.
- R2: Until the first sync fall after reset (sync high on one clock, low on the next), neither valid strobe is asserted, whatever words arrive.
- R3: The word sampled in the clock where sync is first seen low after being high is the blue-difference word, phase 0 of the four-word cycle. That word raises no strobe.
- R4: Words at phase 1 and phase 3 are luma. On the clock after each is sampled, the luma output equals that word and the luma strobe is high for exactly that one cycle.
- R5: On the clock after the phase-2 word (red-difference) is sampled, the chroma strobe is high for one cycle. The red output then equals the phase-2 word and the blue output equals the phase-0 word of the same group.
- R6: With sync held low after locking, the phase advances 0,1,2,3,0 on its own with no limit.
- R7: Raising sync on every phase-3 word (so that it falls on each blue-difference word) keeps the same alignment as free running.
- R8: A sync fall that arrives at any other phase realigns at once. The word in the low clock becomes phase 0, and any pending pair from the old alignment is dropped.
- R9: Sync held high for any number of clocks does not disturb the running phase. Only a high-to-low transition realigns.
- R10: Every 10-bit value, including 0x000, 0x3FF and 8-bit samples with the two low bits zero, reaches the outputs unchanged.
- R11: The two strobes are never high in the same cycle. While a strobe is low, its data outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sync_in | input | 1 | Alignment strobe; a high-to-low transition marks the blue-difference word |
| word_in | input | WORD_W (10) | Multiplexed component word, bit 9 most significant |
| luma_out | output | WORD_W (10) | Last luma sample |
| luma_vld | output | 1 | One-cycle strobe for a new luma sample |
| cb_out | output | WORD_W (10) | Blue-difference sample of the last pair |
| cr_out | output | WORD_W (10) | Red-difference sample of the last pair |
| chroma_vld | output | 1 | One-cycle strobe for a new chroma pair |

## Verification
The case of interest is a sync fall landing on the word that the running counter expects to be red-difference. In that cycle the counter would emit a chroma pair, and the realignment would declare the same word blue-difference. The bench provokes this by raising sync on a luma word and dropping it on the next word. It judges the result with a scoreboard built from the requirements alone. That word must raise no strobe. The next pair must then combine the newly marked blue-difference word with the red-difference word two clocks after it, and no stale sample may appear. The same scoreboard covers realignment on other phases, steady-high sync and a per-group sync pulse.

// File: rtl/vdmx_pkg.sv
package vdmx_pkg;

    localparam int unsigned SEQ_LEN    = 4;
    localparam int unsigned PHASE_W    = $clog2(SEQ_LEN);
    localparam int unsigned NUM_CHROMA = 2;

    typedef enum logic [PHASE_W-1:0] {
        PH_CB = 2'd0,
        PH_Y0 = 2'd1,
        PH_CR = 2'd2,
        PH_Y1 = 2'd3
    } phase_e;

    typedef struct packed {
        logic take_cb;
        logic take_luma;
        logic emit_pair;
    } lane_ctl_t;

    function automatic phase_e phase_after(input phase_e p);
        logic [PHASE_W-1:0] raw;
        raw = p;
        return phase_e'(raw + 1'b1);
    endfunction

    function automatic lane_ctl_t decode_phase(input phase_e p, input logic act);
        lane_ctl_t c;
        c.take_cb   = act && (p == PH_CB);
        c.take_luma = act && ((p == PH_Y0) || (p == PH_Y1));
        c.emit_pair = act && (p == PH_CR);
        return c;
    endfunction

endpackage

// File: rtl/vdmx_sync_detect.sv
module vdmx_sync_detect (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic sync_fall,
    output logic active
);
    logic sync_q;
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            sync_q <= sync_in;
            if (sync_fall) begin
                seen_q <= 1'b1;
            end
        end
    end

    // The low clock of a high-then-low pair carries the blue-difference word
    assign sync_fall = sync_q & ~sync_in;
    assign active    = seen_q | sync_fall;

endmodule

// File: rtl/vdmx_phase_track.sv
module vdmx_phase_track
    import vdmx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sync_fall,
    output phase_e cur_phase
);
    phase_e cnt_q;

    always_comb begin
        cur_phase = sync_fall ? PH_CB : cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= PH_CB;
        end else begin
            cnt_q <= phase_after(cur_phase);
        end
    end

endmodule

// File: rtl/vdmx_lane_capture.sv
module vdmx_lane_capture
    import vdmx_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] luma_out,
    output logic         luma_vld,
    output logic [W-1:0] cb_out,
    output logic [W-1:0] cr_out,
    output logic         chroma_vld
);
    logic [W-1:0] chroma_d [NUM_CHROMA];

    always_ff @(posedge clk) begin
        if (rst) begin
            luma_out   <= '0;
            luma_vld   <= 1'b0;
            chroma_vld <= 1'b0;
        end else begin
            luma_vld   <= ctl.take_luma;
            chroma_vld <= ctl.emit_pair;
            if (ctl.take_luma) begin
                luma_out <= word_in;
            end
        end
    end

    // Lane 0 arrives two words ahead of its partner and waits in a hold register;
    // lane 1 is loaded straight from the input when the pair completes.
    for (genvar gi = 0; gi < NUM_CHROMA; gi++) begin : g_chroma
        logic [W-1:0] lane_q;
        if (gi == 0) begin : g_early
            logic [W-1:0] hold_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= '0;
                    lane_q <= '0;
                end else begin
                    if (ctl.take_cb) begin
                        hold_q <= word_in;
                    end
                    if (ctl.emit_pair) begin
                        lane_q <= hold_q;
                    end
                end
            end
        end else begin : g_late
            always_ff @(posedge clk) begin
                if (rst) begin
                    lane_q <= '0;
                end else if (ctl.emit_pair) begin
                    lane_q <= word_in;
                end
            end
        end
        assign chroma_d[gi] = lane_q;
    end

    assign cb_out = chroma_d[0];
    assign cr_out = chroma_d[1];

endmodule

// File: rtl/vid422_demux.sv
module vid422_demux
    import vdmx_pkg::*;
#(
    parameter int unsigned WORD_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_in,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] luma_out,
    output logic              luma_vld,
    output logic [WORD_W-1:0] cb_out,
    output logic [WORD_W-1:0] cr_out,
    output logic              chroma_vld
);
    logic      sync_fall;
    logic      active;
    phase_e    cur_phase;
    lane_ctl_t ctl;

    vdmx_sync_detect u_sync (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .sync_fall (sync_fall),
        .active    (active)
    );

    vdmx_phase_track u_phase (
        .clk       (clk),
        .rst       (rst),
        .sync_fall (sync_fall),
        .cur_phase (cur_phase)
    );

    always_comb begin
        ctl = decode_phase(cur_phase, active);
    end

    vdmx_lane_capture #(.W(WORD_W)) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .word_in    (word_in),
        .luma_out   (luma_out),
        .luma_vld   (luma_vld),
        .cb_out     (cb_out),
        .cr_out     (cr_out),
        .chroma_vld (chroma_vld)
    );

endmodule

// File: rtl/vdmx_demux_chk.sv
module vdmx_demux_chk #(
    parameter int unsigned W = 10
) (
    input logic         clk,
    input logic         rst,
    input logic         sync_in,
    input logic [W-1:0] word_in,
    input logic [W-1:0] luma_out,
    input logic         luma_vld,
    input logic [W-1:0] cr_out,
    input logic         chroma_vld
);
    logic prev_sync_q;
    logic seen_q;
    logic edge_now;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_sync_q <= 1'b0;
            seen_q      <= 1'b0;
        end else begin
            prev_sync_q <= sync_in;
            if (edge_now) begin
                seen_q <= 1'b1;
            end
        end
    end

    assign edge_now = prev_sync_q && !sync_in;
    assign armed    = seen_q || edge_now;

    a_r2_quiet_until_lock: assert property (@(posedge clk) disable iff (rst)
        !armed |=> (!luma_vld && !chroma_vld));

    a_r3_cb_word_no_strobe: assert property (@(posedge clk) disable iff (rst)
        edge_now |=> (!luma_vld && !chroma_vld));

    a_r4_luma_follows_pair: assert property (@(posedge clk) disable iff (rst)
        (chroma_vld && !edge_now) |=> luma_vld);

    a_r5_pair_single_cycle: assert property (@(posedge clk) disable iff (rst)
        chroma_vld |=> !chroma_vld);

    a_r10_luma_unchanged: assert property (@(posedge clk) disable iff (rst)
        luma_vld |-> (luma_out == $past(word_in)));

    a_r10_cr_unchanged: assert property (@(posedge clk) disable iff (rst)
        chroma_vld |-> (cr_out == $past(word_in)));

    a_r11_exclusive_strobes: assert property (@(posedge clk) disable iff (rst)
        $onehot0({luma_vld, chroma_vld}));

endmodule

bind vid422_demux vdmx_demux_chk #(.W(WORD_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_in    (sync_in),
    .word_in    (word_in),
    .luma_out   (luma_out),
    .luma_vld   (luma_vld),
    .cr_out     (cr_out),
    .chroma_vld (chroma_vld)
);

// File: tb/vid422_demux_tb.sv
module vid422_demux_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       lv;
        logic [9:0] l;
        logic       cv;
        logic [9:0] cb;
        logic [9:0] cr;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_in = 1'b0;
    logic [9:0] word_in = '0;
    logic [9:0] luma_out, cb_out, cr_out;
    logic       luma_vld, chroma_vld;

    int checks = 0;
    int fails  = 0;

    exp_t  expq[$];
    string tagq[$];

    // reference state, derived from the requirements
    logic       m_prev_sync = 1'b0;
    logic       m_seen = 1'b0;
    int         m_ph = 0;
    logic [9:0] m_hold = '0;
    logic [9:0] m_l = '0, m_cb = '0, m_cr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid422_demux u_dut (
        .clk(clk), .rst(rst), .sync_in(sync_in), .word_in(word_in),
        .luma_out(luma_out), .luma_vld(luma_vld),
        .cb_out(cb_out), .cr_out(cr_out), .chroma_vld(chroma_vld)
    );

    task automatic push_word(input logic [9:0] w, input logic s, input string tag);
        exp_t e;
        logic fall;
        int   ph;
        @(negedge clk);
        word_in = w;
        sync_in = s;
        fall = m_prev_sync && !s;
        ph   = fall ? 0 : m_ph;
        e.lv = 1'b0;
        e.cv = 1'b0;
        if (m_seen || fall) begin
            case (ph)
                0: m_hold = w;
                1, 3: begin m_l = w; e.lv = 1'b1; end
                default: begin m_cb = m_hold; m_cr = w; e.cv = 1'b1; end
            endcase
        end
        e.l  = m_l;
        e.cb = m_cb;
        e.cr = m_cr;
        m_ph = (ph + 1) % 4;
        m_prev_sync = s;
        m_seen = m_seen || fall;
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic send_group(input logic [9:0] cb, y0, cr, y1,
                              input logic s_all, input logic s_last, input string tag);
        push_word(cb, s_all, tag);
        push_word(y0, s_all, tag);
        push_word(cr, s_all, tag);
        push_word(y1, s_all | s_last, tag);
    endtask

    // monitor: compare one expected item per driven word
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) begin
            exp_t  e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            checks++;
            if (luma_vld !== e.lv || chroma_vld !== e.cv || luma_out !== e.l ||
                cb_out !== e.cb || cr_out !== e.cr || (luma_vld && chroma_vld)) begin
                fails++;
                $display("FAIL %s (R11 exclusivity included): actual lv=%b l=%h cv=%b cb=%h cr=%h expected lv=%b l=%h cv=%b cb=%h cr=%h",
                         t, luma_vld, luma_out, chroma_vld, cb_out, cr_out,
                         e.lv, e.l, e.cv, e.cb, e.cr);
            end
        end
    end

    task automatic check_reset_state(input string when);
        checks++;
        if (luma_vld !== 1'b0 || chroma_vld !== 1'b0 || luma_out !== '0 ||
            cb_out !== '0 || cr_out !== '0) begin
            fails++;
            $display("FAIL R1 %s: actual lv=%b cv=%b l=%h cb=%h cr=%h expected all zero",
                     when, luma_vld, chroma_vld, luma_out, cb_out, cr_out);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL R6 watchdog: actual run still going, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        sync_in = 1'b1;
        word_in = 10'h2AA;
        repeat (3) @(posedge clk);
        #1;
        check_reset_state("during reset");
        @(negedge clk);
        rst = 1'b0;
        sync_in = 1'b0;
        @(posedge clk);
        #1;
        check_reset_state("first cycle after reset");

        // R2: data without any sync fall
        for (int i = 0; i < 8; i++) push_word(10'(10'h050 + i), 1'b0, "R2");

        // R3: lock on high-then-low, first CB in the low clock
        push_word(10'h155, 1'b1, "R3");
        send_group(10'h040, 10'h041, 10'h042, 10'h043, 1'b0, 1'b0, "R3");
        send_group(10'h080, 10'h081, 10'h082, 10'h083, 1'b0, 1'b0, "R4");
        send_group(10'h0C0, 10'h0C1, 10'h0C2, 10'h0C3, 1'b0, 1'b0, "R5");
        // R6: free running with sync low
        for (int g = 0; g < 3; g++)
            send_group(10'(10'h100 + 16*g), 10'(10'h101 + 16*g),
                       10'(10'h102 + 16*g), 10'(10'h103 + 16*g), 1'b0, 1'b0, "R6");

        // R7: sync pulsed before every CB word
        for (int g = 0; g < 4; g++)
            send_group(10'(10'h200 + 16*g), 10'(10'h201 + 16*g),
                       10'(10'h202 + 16*g), 10'(10'h203 + 16*g), 1'b0, 1'b1, "R7");

        // R8: fall lands on the word expected to be CR
        push_word(10'h111, 1'b0, "R8");
        push_word(10'h112, 1'b1, "R8");
        send_group(10'h120, 10'h121, 10'h122, 10'h123, 1'b0, 1'b0, "R8");
        // R8: fall lands on the word expected to be first luma
        push_word(10'h130, 1'b1, "R8");
        send_group(10'h140, 10'h141, 10'h142, 10'h143, 1'b0, 1'b0, "R8");
        // R8: fall lands on the word expected to be isolated luma
        push_word(10'h150, 1'b0, "R8");
        push_word(10'h151, 1'b0, "R8");
        push_word(10'h152, 1'b1, "R8");
        send_group(10'h160, 10'h161, 10'h162, 10'h163, 1'b0, 1'b0, "R8");

        // R9: sync held high across groups does not move the phase
        send_group(10'h300, 10'h301, 10'h302, 10'h303, 1'b1, 1'b1, "R9");
        send_group(10'h310, 10'h311, 10'h312, 10'h313, 1'b1, 1'b1, "R9");
        push_word(10'h320, 1'b1, "R9");
        push_word(10'h321, 1'b1, "R9");
        push_word(10'h322, 1'b0, "R9");
        send_group(10'h330, 10'h331, 10'h332, 10'h333, 1'b0, 1'b0, "R9");

        // R10: extreme and 8-bit style values
        send_group(10'h000, 10'h3FF, 10'h3FF, 10'h000, 1'b0, 1'b0, "R10");
        send_group(10'h3FC, 10'h004, 10'h200, 10'h3FC, 1'b0, 1'b0, "R10");
        send_group(10'h3FF, 10'h3FF, 10'h000, 10'h3FF, 1'b0, 1'b0, "R10");
        // R11: outputs hold between strobes
        for (int i = 0; i < 4; i++) push_word(10'(10'h0AA + i), 1'b0, "R11");

        repeat (3) @(posedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule